// File: doc/BRIEF.md
# Card-Write Transmit FIFO Controller

This block sits between a host bus (or a DMA engine acting for it) and the data engine that clocks bytes out to a storage card during write transfers. The host writes through one 32-bit transmit data port. Each write carries a lane code that says how many of its bytes are valid, and only those bytes enter a byte-wide FIFO. The card-side engine drains the FIFO one byte at a time over a valid/ready handshake. A level output tells that engine when the FIFO holds nothing.

While a transfer is active, the block watches the fill level against a programmable threshold of 16 or 32 bytes. Once the level has reached the threshold, a later drop below it raises a single one-cycle DMA write request. Further requests are then locked out until the DMA engine reports completion, and draining continues meanwhile. Each request sets a sticky ready status bit, and the interrupt output is that bit gated by an enable. No request comes from simply starting a transfer, so software fills the FIFO before it starts the card write.

A soft reset flushes the FIFO contents and the request handshake state. It keeps the threshold, the interrupt enable and the status bits. Only the hardware reset returns those to their defaults.

Top module: `cwtx_top`

## Requirements
- R1: A host write with lane code c (0..3) pushes exactly c+1 bytes, taken from bits [7:0] upward, and the card side receives them lowest lane first, in write order.
- R2: card_valid is high whenever the FIFO holds at least one byte, card_data shows the oldest byte, and one byte leaves on each clock edge where card_valid and card_ready are both high.
- R3: A host write whose valid bytes do not all fit in the free space is dropped whole and sets sts_ovf. Bit 1 of sts_clr clears sts_ovf.
- R4: card_empty is high exactly when the FIFO holds zero bytes.
- R5: The threshold select is 0 for 16 bytes and 1 for 32 bytes. While xfer_active is high and the block is armed and not locked, a fill level below the threshold makes dma_req high for one cycle, in the cycle after the level is first below the threshold.
- R6: After a request, no further request is raised until dma_done is seen, even if the FIFO keeps draining to empty.
- R7: After dma_done, a fill level still below the threshold raises a new request.
- R8: No request is raised while xfer_active is low. No request is raised at the start of a transfer until the fill level has reached the threshold during that transfer.
- R9: Every request sets sts_rdy. Bit 0 of sts_clr clears sts_rdy, with a set in the same cycle taking priority. irq_rdy equals sts_rdy AND the interrupt enable.
- R10: soft_rst empties the FIFO and clears the lockout and arming. It keeps the threshold select, the interrupt enable, sts_rdy and sts_ovf.
- R11: The hardware reset gives an empty FIFO, threshold select 0, interrupt enable 0, both status bits 0 and dma_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| soft_rst | input | 1 | Soft reset: flushes the data path and keeps configuration and status |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_thr_sel | input | 1 | Threshold select written on cfg_we (0 = 16 bytes, 1 = 32 bytes) |
| cfg_irq_en | input | 1 | Interrupt enable written on cfg_we |
| sts_clr | input | 2 | Write-one-to-clear: bit 0 clears sts_rdy, bit 1 clears sts_ovf |
| host_wr | input | 1 | Transmit data write strobe |
| host_lanes | input | 2 | Valid byte count minus one |
| host_wdata | input | 32 | Transmit data, byte lanes from bit 0 upward |
| xfer_active | input | 1 | A write transfer is in progress |
| dma_done | input | 1 | The DMA engine has finished the outstanding request |
| dma_req | output | 1 | One-cycle DMA write request |
| sts_rdy | output | 1 | Sticky transmit-ready status |
| sts_ovf | output | 1 | Sticky overflow status |
| irq_rdy | output | 1 | Transmit-ready interrupt |
| card_data | output | 8 | Oldest byte in the FIFO |
| card_valid | output | 1 | card_data is valid |
| card_ready | input | 1 | The card engine takes card_data |
| card_empty | output | 1 | The FIFO holds no bytes |

## Verification
The hardest situation to reach from the ports is a level that stays below the threshold after a request has been issued. The lockout must hold while the FIFO drains to empty, and a second request must follow at once when dma_done arrives. The bench prefills the FIFO above the threshold and starts the transfer, then pops bytes one at a time so that it knows the exact cycle of the crossing. It keeps popping with no completion, then pulses dma_done. A pulse counter on dma_req confirms one request per lockout window. A soft reset between transfers, with the 32-byte threshold selected, shows that the retained threshold still governs the next crossing.

// File: rtl/cwtx_pkg.sv
package cwtx_pkg;

  localparam int unsigned LANES = 4;

  typedef struct packed {
    logic thr_sel;
    logic irq_en;
  } cwtx_cfg_t;

  // number of valid bytes carried by a host write lane code
  function automatic logic [2:0] lanes_from_code(input logic [1:0] code);
    return {1'b0, code} + 3'd1;
  endfunction

  // does a write of n bytes fit next to cnt stored bytes
  function automatic logic write_fits(input int unsigned cnt, input int unsigned n,
                                      input int unsigned depth);
    return (cnt + n) <= depth;
  endfunction

endpackage

// File: rtl/cwtx_byte_fifo.sv
module cwtx_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int NW    = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               push,
  input  logic [NW-1:0]      push_n,
  input  logic [8*LANES-1:0] push_data,
  input  logic               pop,
  output logic [7:0]         rd_data,
  output logic [CW-1:0]      fill
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW-1:0] lane_addr [LANES];
  logic          lane_en   [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_addr[g] = wr_ptr + AW'(g);
    assign lane_en[g]   = push && (NW'(g) < push_n);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (lane_en[i]) mem[lane_addr[i]] <= push_data[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(push_n);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      fill <= fill + (push ? CW'(push_n) : CW'(0)) - (pop ? CW'(1) : CW'(0));
    end
  end

  assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/cwtx_req_ctrl.sv
module cwtx_req_ctrl #(
  parameter int THR_LO = 16,
  parameter int THR_HI = 32,
  parameter int CW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          xfer_active,
  input  logic          thr_sel,
  input  logic [CW-1:0] fill,
  input  logic          dma_done,
  output logic          req_fire,
  output logic          dma_req,
  output logic          locked,
  output logic          armed
);
  localparam logic [CW-1:0] LO_W = CW'(THR_LO);
  localparam logic [CW-1:0] HI_W = CW'(THR_HI);

  logic [CW-1:0] thr_level;
  logic          below;

  assign thr_level = thr_sel ? HI_W : LO_W;
  assign below     = fill < thr_level;
  assign req_fire  = xfer_active && armed && !locked && below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      locked  <= 1'b0;
      dma_req <= 1'b0;
    end else if (flush || !xfer_active) begin
      armed   <= 1'b0;
      locked  <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      dma_req <= req_fire;
      if (!below) armed <= 1'b1;
      if (req_fire)      locked <= 1'b1;
      else if (dma_done) locked <= 1'b0;
    end
  end

endmodule

// File: rtl/cwtx_regs.sv
module cwtx_regs
  import cwtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  cwtx_cfg_t  cfg_in,
  input  logic [1:0] sts_clr,
  input  logic       rdy_set,
  input  logic       ovf_set,
  output cwtx_cfg_t  cfg,
  output logic       sts_rdy,
  output logic       sts_ovf,
  output logic       irq_rdy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      sts_rdy <= 1'b0;
      sts_ovf <= 1'b0;
    end else begin
      if (cfg_we) cfg <= cfg_in;
      if (rdy_set)         sts_rdy <= 1'b1;
      else if (sts_clr[0]) sts_rdy <= 1'b0;
      if (ovf_set)         sts_ovf <= 1'b1;
      else if (sts_clr[1]) sts_ovf <= 1'b0;
    end
  end

  assign irq_rdy = sts_rdy & cfg.irq_en;

endmodule

// File: rtl/cwtx_top.sv
module cwtx_top
  import cwtx_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int THR_LO = 16,
  parameter int THR_HI = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        cfg_we,
  input  logic        cfg_thr_sel,
  input  logic        cfg_irq_en,
  input  logic [1:0]  sts_clr,
  input  logic        host_wr,
  input  logic [1:0]  host_lanes,
  input  logic [31:0] host_wdata,
  input  logic        xfer_active,
  input  logic        dma_done,
  output logic        dma_req,
  output logic        sts_rdy,
  output logic        sts_ovf,
  output logic        irq_rdy,
  output logic [7:0]  card_data,
  output logic        card_valid,
  input  logic        card_ready,
  output logic        card_empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int NW = $clog2(LANES + 1);

  // named internal events, visible to the checker
  logic [CW-1:0] fill;
  logic [2:0]    wr_bytes;
  logic          wr_fits;
  logic          push_ok;
  logic          ovf_evt;
  logic          pop;
  logic          req_fire;
  logic          req_locked;
  logic          req_armed;
  cwtx_cfg_t     cfg_in, cfg;

  assign wr_bytes = lanes_from_code(host_lanes);
  assign wr_fits  = write_fits(32'(fill), 32'(wr_bytes), DEPTH);
  assign push_ok  = host_wr && wr_fits && !soft_rst;
  assign ovf_evt  = host_wr && !wr_fits && !soft_rst;
  assign pop      = card_valid && card_ready && !soft_rst;

  assign card_valid = (fill != '0);
  assign card_empty = (fill == '0);

  assign cfg_in.thr_sel = cfg_thr_sel;
  assign cfg_in.irq_en  = cfg_irq_en;

  cwtx_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES), .CW(CW), .NW(NW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (soft_rst),
    .push      (push_ok),
    .push_n    (NW'(wr_bytes)),
    .push_data (host_wdata),
    .pop       (pop),
    .rd_data   (card_data),
    .fill      (fill)
  );

  cwtx_req_ctrl #(.THR_LO(THR_LO), .THR_HI(THR_HI), .CW(CW)) u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (soft_rst),
    .xfer_active (xfer_active),
    .thr_sel     (cfg.thr_sel),
    .fill        (fill),
    .dma_done    (dma_done),
    .req_fire    (req_fire),
    .dma_req     (dma_req),
    .locked      (req_locked),
    .armed       (req_armed)
  );

  cwtx_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_in  (cfg_in),
    .sts_clr (sts_clr),
    .rdy_set (req_fire),
    .ovf_set (ovf_evt),
    .cfg     (cfg),
    .sts_rdy (sts_rdy),
    .sts_ovf (sts_ovf),
    .irq_rdy (irq_rdy)
  );

endmodule

// File: rtl/cwtx_chk.sv
module cwtx_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          dma_req,
  input logic          dma_done,
  input logic          xfer_active,
  input logic          sts_rdy,
  input logic          sts_ovf,
  input logic          irq_rdy,
  input logic [1:0]    sts_clr,
  input logic          card_valid,
  input logic          card_empty,
  input logic [CW-1:0] fill,
  input logic          req_locked
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH)); // R3

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sts_ovf && !sts_clr[1] |=> sts_ovf); // R3

  AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    card_empty |-> !card_valid); // R4

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req); // R6

  AST_REQ_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && xfer_active && !soft_rst |-> req_locked); // R6

  AST_REQ_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(xfer_active)); // R8

  AST_REQ_SETS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> sts_rdy); // R9

  AST_IRQ_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rdy |-> sts_rdy); // R9

  AST_SOFT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> card_empty && !dma_req); // R10

  AST_DONE_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    req_locked && dma_done && !dma_req |=> !req_locked); // R7
endmodule

bind cwtx_top cwtx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst),
  .dma_req     (dma_req),
  .dma_done    (dma_done),
  .xfer_active (xfer_active),
  .sts_rdy     (sts_rdy),
  .sts_ovf     (sts_ovf),
  .irq_rdy     (irq_rdy),
  .sts_clr     (sts_clr),
  .card_valid  (card_valid),
  .card_empty  (card_empty),
  .fill        (fill),
  .req_locked  (req_locked)
);

// File: tb/test_cwtx_top.sv
module test_cwtx_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {lane code, data}
  localparam logic [33:0] VEC [NVEC] = '{
    {2'd0, 32'hAABBCC11},
    {2'd1, 32'h99887722},
    {2'd2, 32'h55443333},
    {2'd3, 32'h44444444},
    {2'd3, 32'hD5C5B5A5},
    {2'd1, 32'hEEEEF6E6}
  };

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic cfg_we = 1'b0, cfg_thr_sel = 1'b0, cfg_irq_en = 1'b0;
  logic [1:0] sts_clr = 2'b00;
  logic host_wr = 1'b0;
  logic [1:0] host_lanes = 2'd0;
  logic [31:0] host_wdata = '0;
  logic xfer_active = 1'b0, dma_done = 1'b0, card_ready = 1'b0;
  logic dma_req, sts_rdy, sts_ovf, irq_rdy, card_valid, card_empty;
  logic [7:0] card_data;

  int n_cmp = 0, n_bad = 0, n_pulse = 0;
  logic [7:0] exp_b [64];
  int exp_n;
  logic [7:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n && dma_req) n_pulse++;

  cwtx_top i_cwtx_top (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwrite(input logic [1:0] code, input logic [31:0] d);
    host_wr = 1'b1; host_lanes = code; host_wdata = d;
    tick(1);
    host_wr = 1'b0;
  endtask

  task automatic cfg(input logic thr, input logic ie);
    cfg_we = 1'b1; cfg_thr_sel = thr; cfg_irq_en = ie;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic pop_one(output logic [7:0] b);
    b = card_data;
    card_ready = 1'b1;
    tick(1);
    card_ready = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int p0;
    tick(2);
    // R11 reset state
    chk("R11 card_empty", card_empty, 1);
    chk("R11 sts_rdy", sts_rdy, 0);
    chk("R11 sts_ovf", sts_ovf, 0);
    chk("R11 irq_rdy", irq_rdy, 0);
    chk("R11 dma_req", dma_req, 0);
    rst_n = 1'b1;
    tick(1);
    chk("R4 empty after reset", card_empty, 1);

    // R1/R2: table of partial writes, expected byte stream built here
    exp_n = 0;
    for (int v = 0; v < NVEC; v++) begin
      for (int l = 0; l <= int'(VEC[v][33:32]); l++) begin
        exp_b[exp_n] = VEC[v][8*l +: 8];
        exp_n++;
      end
      hwrite(VEC[v][33:32], VEC[v][31:0]);
    end
    chk("R2 valid with data", card_valid, 1);
    chk("R4 not empty with data", card_empty, 0);
    for (int k = 0; k < exp_n; k++) begin
      chk("R2 valid while draining", card_valid, 1);
      pop_one(got);
      chk($sformatf("R1 byte %0d", k), got, exp_b[k]);
    end
    chk("R4 empty after drain", card_empty, 1);
    chk("R2 valid low when empty", card_valid, 0);
    chk("R8 no request while inactive", n_pulse, 0);

    // R3 overflow
    for (int w = 0; w < 8; w++) hwrite(2'd3, {4{8'(w)}});
    chk("R3 no ovf at exact fill", sts_ovf, 0);
    hwrite(2'd0, 32'h000000EE);
    chk("R3 ovf set", sts_ovf, 1);
    for (int k = 0; k < 32; k++) pop_one(got);
    chk("R3 dropped write not stored", got, 8'h07);
    chk("R3 empty after 32 pops", card_empty, 1);
    sts_clr = 2'b10; tick(1); sts_clr = 2'b00;
    chk("R3 ovf cleared", sts_ovf, 0);

    // R5/R6/R7 request, lockout, re-request
    cfg(1'b0, 1'b1);
    for (int w = 0; w < 5; w++) hwrite(2'd3, 32'h01020304);
    xfer_active = 1'b1;
    tick(4);
    chk("R5 no request above threshold", n_pulse, 0);
    for (int k = 0; k < 5; k++) pop_one(got);
    chk("R5 request not yet", dma_req, 0);
    tick(1);
    chk("R5 request cycle after crossing", dma_req, 1);
    tick(1);
    chk("R5 request one cycle", dma_req, 0);
    chk("R9 sts_rdy set", sts_rdy, 1);
    chk("R9 irq with enable", irq_rdy, 1);
    for (int k = 0; k < 15; k++) pop_one(got);
    tick(3);
    chk("R4 empty while locked", card_empty, 1);
    chk("R6 locked out", n_pulse, 1);
    dma_done = 1'b1; tick(1); dma_done = 1'b0;
    tick(2);
    chk("R7 re-request after done", n_pulse, 2);

    // R10 soft reset retains threshold, enable and status
    xfer_active = 1'b0;
    cfg(1'b1, 1'b1);
    for (int w = 0; w < 3; w++) hwrite(2'd3, 32'h0);
    soft_rst = 1'b1; tick(1); soft_rst = 1'b0;
    chk("R10 flushed", card_empty, 1);
    chk("R10 sts_rdy kept", sts_rdy, 1);
    chk("R10 irq enable kept", irq_rdy, 1);
    p0 = n_pulse;
    xfer_active = 1'b1;
    tick(10);
    chk("R8 no request at start", n_pulse, p0);
    for (int w = 0; w < 8; w++) hwrite(2'd3, 32'h0);
    tick(2);
    chk("R8 none while filling", n_pulse, p0);
    pop_one(got);
    tick(3);
    chk("R10 threshold 32 kept", n_pulse, p0 + 1);

    // R9 enable gating and write-one-to-clear
    cfg(1'b1, 1'b0);
    chk("R9 irq masked", irq_rdy, 0);
    chk("R9 sts still set", sts_rdy, 1);
    sts_clr = 2'b01; tick(1); sts_clr = 2'b00;
    chk("R9 sts cleared", sts_rdy, 0);
    xfer_active = 1'b0;

    // R11 hardware reset mid-operation
    rst_n = 1'b0; tick(2);
    chk("R11 empty", card_empty, 1);
    chk("R11 sts_rdy", sts_rdy, 0);
    rst_n = 1'b1; tick(1);
    cfg_we = 1'b0;
    chk("R11 irq low", irq_rdy, 0);
    summary();
  end
endmodule